// File: doc/BRIEF.md
# Machine/Supervisor Status Register

This block holds the privileged status word of a processor hart and serves two software views of it. The machine view reads and writes the whole register. The supervisor view is a restricted window onto the same storage. Software can change only a fixed set of writable fields. The summary-dirty bit in the top position is never taken from write data: hardware recomputes it from the floating-point and extension state fields each time the register is written.

Each cycle, a small selector picks at most one write source. The selector has three states. SRC_IDLE means no write and the register holds. SRC_MACH means the machine port writes. SRC_SUPV means the supervisor port writes. The selector makes a fresh choice every cycle with no history. Any state goes to SRC_MACH when the machine enable is high. Any state goes to SRC_SUPV when only the supervisor enable is high. Any state goes to SRC_IDLE when neither enable is high.

A supervisor write first overlays its data onto the current value under the supervisor-visible mask. The merged word then takes the same filtered path as a machine write. A write that changes a field affecting address translation raises a single-cycle flush pulse, for the translation caches outside this block. XLEN must be at least 32.

Top module: `mstat_core`

## Requirements
- R1: After reset, status_o equals 0x1800: every bit is 0 except the previous-privilege field [12:11], which is 3. supv_view_o and xlat_flush_o are 0.
- R2: A machine write changes only these bits: 1, 3, 5, 7, 8, 11-12, 13-14, 17, 18, 19, 20, 21 and 22. Every other bit below XLEN-1 keeps its old value.
- R3: After any write, bit XLEN-1 is 1 exactly when [14:13] equals 3 or [16:15] equals 3. The value written into that bit has no effect.
- R4: supv_view_o always equals status_o ANDed with the supervisor mask. That mask covers bits 0, 1, 4, 5, 8, 13-14, 15-16, 18, 19 and XLEN-1.
- R5: A supervisor write merges its data into the current value under the supervisor mask, and then applies the R2 filter. So only bits 1, 5, 8, 13-14, 18 and 19 can change. Data on bits 0, 4, 15-16 and XLEN-1, and on machine-only fields, has no effect.
- R6: xlat_flush_o is high for exactly one cycle, in the cycle a write's result first appears, if that write changed any of bits 11-12, 17, 18 or 19. Otherwise it is low.
- R7: When both write enables are high in the same cycle, only the machine data is used.
- R8: When neither write enable is high, status_o does not change.
- R9: A write sampled at a rising edge shows on status_o from that edge on, which is one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mach_we_i | input | 1 | Machine-view write enable |
| mach_wdata_i | input | XLEN | Machine-view write data |
| supv_we_i | input | 1 | Supervisor-view write enable |
| supv_wdata_i | input | XLEN | Supervisor-view write data |
| status_o | output | XLEN | Full status register |
| supv_view_o | output | XLEN | Supervisor read value (masked) |
| xlat_flush_o | output | 1 | One-cycle translation flush request |

## Verification
The assertions assume that the write enables and write data are stable around the rising edge, and that XLEN is at least 32. The priority and merge properties also assume that the enables are never unknown once reset is released. The bench changes every input only on the falling edge and drives every enable to a known 0 or 1 from time zero. It mixes directed corner values with a software-generated pseudo-random sequence that covers all four combinations of the enables.

// File: rtl/mstat_pkg.sv
`timescale 1ns/1ps
package mstat_pkg;

    // Field positions inside the status word
    localparam int unsigned UIE_B  = 0;
    localparam int unsigned SIE_B  = 1;
    localparam int unsigned MIE_B  = 3;
    localparam int unsigned UPIE_B = 4;
    localparam int unsigned SPIE_B = 5;
    localparam int unsigned MPIE_B = 7;
    localparam int unsigned SPP_B  = 8;
    localparam int unsigned MPP_LO = 11;
    localparam int unsigned FS_LO  = 13;
    localparam int unsigned XS_LO  = 15;
    localparam int unsigned MPRV_B = 17;
    localparam int unsigned SUM_B  = 18;
    localparam int unsigned MXR_B  = 19;
    localparam int unsigned TVM_B  = 20;
    localparam int unsigned TW_B   = 21;
    localparam int unsigned TSR_B  = 22;

    // Width of the low field area (everything except the top summary bit)
    localparam int unsigned LOW_W  = 23;

    localparam logic [LOW_W-1:0] L1 = 1;
    localparam logic [LOW_W-1:0] L3 = 3;

    // Fields a machine write may change
    localparam logic [LOW_W-1:0] MACH_LOW =
        (L1 << SIE_B)  | (L1 << MIE_B)  | (L1 << SPIE_B) | (L1 << MPIE_B) |
        (L1 << SPP_B)  | (L3 << MPP_LO) | (L3 << FS_LO)  | (L1 << MPRV_B) |
        (L1 << SUM_B)  | (L1 << MXR_B)  | (L1 << TVM_B)  | (L1 << TW_B)   |
        (L1 << TSR_B);

    // Fields visible through the supervisor window (summary bit added per XLEN)
    localparam logic [LOW_W-1:0] SUPV_LOW =
        (L1 << UIE_B)  | (L1 << SIE_B)  | (L1 << UPIE_B) | (L1 << SPIE_B) |
        (L1 << SPP_B)  | (L3 << FS_LO)  | (L3 << XS_LO)  | (L1 << SUM_B)  |
        (L1 << MXR_B);

    // Fields whose change requires a translation flush
    localparam logic [LOW_W-1:0] FLUSH_LOW =
        (L3 << MPP_LO) | (L1 << MPRV_B) | (L1 << SUM_B) | (L1 << MXR_B);

    // Reset value of the low area: previous privilege = machine
    localparam logic [LOW_W-1:0] RESET_LOW = (L3 << MPP_LO);

    // Write-source selection
    typedef enum logic [1:0] {
        SRC_IDLE = 2'd0,
        SRC_MACH = 2'd1,
        SRC_SUPV = 2'd2
    } wr_src_e;

endpackage

// File: rtl/mstat_arb.sv
`timescale 1ns/1ps
module mstat_arb
    import mstat_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            mach_we_i,
    input  logic [XLEN-1:0] mach_wdata_i,
    input  logic            supv_we_i,
    input  logic [XLEN-1:0] supv_wdata_i,
    input  logic [XLEN-1:0] cur_i,
    output logic            wr_vld_o,
    output logic [XLEN-1:0] wr_raw_o
);

    localparam logic [XLEN-1:0] SD_BIT  = XLEN'(1) << (XLEN - 1);
    localparam logic [XLEN-1:0] SV_MASK = XLEN'(SUPV_LOW) | SD_BIT;

    wr_src_e src;

    // Source selection: machine port has priority
    always_comb begin
        if (mach_we_i) begin
            src = SRC_MACH;
        end else if (supv_we_i) begin
            src = SRC_SUPV;
        end else begin
            src = SRC_IDLE;
        end
    end

    // Raw write word for the chosen source
    always_comb begin
        wr_vld_o = 1'b0;
        wr_raw_o = cur_i;
        unique case (src)
            SRC_MACH: begin
                wr_vld_o = 1'b1;
                wr_raw_o = mach_wdata_i;
            end
            SRC_SUPV: begin
                wr_vld_o = 1'b1;
                wr_raw_o = (cur_i & ~SV_MASK) | (supv_wdata_i & SV_MASK);
            end
            SRC_IDLE: begin
                wr_vld_o = 1'b0;
            end
            default: begin
                wr_vld_o = 1'b0;
            end
        endcase
    end

    // R7
    mach_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mach_we_i |-> (wr_vld_o && (wr_raw_o == mach_wdata_i)));

    // R5
    supv_merge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (supv_we_i && !mach_we_i) |-> ((wr_raw_o & ~SV_MASK) == (cur_i & ~SV_MASK)));

    // R8
    idle_novld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mach_we_i && !supv_we_i) |-> !wr_vld_o);

endmodule

// File: rtl/mstat_filter.sv
`timescale 1ns/1ps
module mstat_filter
    import mstat_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [XLEN-1:0] cur_i,
    input  logic [XLEN-1:0] raw_i,
    output logic [XLEN-1:0] nxt_o
);

    localparam logic [XLEN-1:0] MW_MASK = XLEN'(MACH_LOW);
    localparam int unsigned     SD_POS  = XLEN - 1;

    logic [XLEN-1:0] merged;
    logic            dirty;

    always_comb begin
        merged = (cur_i & ~MW_MASK) | (raw_i & MW_MASK);
        dirty  = (&merged[FS_LO+1:FS_LO]) | (&merged[XS_LO+1:XS_LO]);
        nxt_o  = merged;
        nxt_o[SD_POS] = dirty;
    end

endmodule

// File: rtl/mstat_reg.sv
`timescale 1ns/1ps
module mstat_reg
    import mstat_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            wr_vld_i,
    input  logic [XLEN-1:0] nxt_i,
    output logic [XLEN-1:0] status_o,
    output logic            flush_o
);

    localparam logic [XLEN-1:0] RST_VAL  = XLEN'(RESET_LOW);
    localparam logic [XLEN-1:0] FL_MASK  = XLEN'(FLUSH_LOW);
    localparam logic [XLEN-1:0] SD_BIT   = XLEN'(1) << (XLEN - 1);
    localparam logic [XLEN-1:0] LOCKED   = ~(XLEN'(MACH_LOW) | SD_BIT);

    logic [XLEN-1:0] status_q;
    logic            flush_q;
    logic            flush_d;

    always_comb begin
        flush_d = wr_vld_i && (((nxt_i ^ status_q) & FL_MASK) != '0);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            status_q <= RST_VAL;
            flush_q  <= 1'b0;
        end else begin
            if (wr_vld_i) begin
                status_q <= nxt_i;
            end
            flush_q <= flush_d;
        end
    end

    assign status_o = status_q;
    assign flush_o  = flush_q;

    // R2
    locked_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_vld_i |=> ((status_q & LOCKED) == ($past(status_q) & LOCKED)));

    // R3
    sd_derive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        status_q[XLEN-1] == ((&status_q[FS_LO+1:FS_LO]) | (&status_q[XS_LO+1:XS_LO])));

    // R6
    flush_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_q == ((status_q & FL_MASK) != ($past(status_q) & FL_MASK)));

    // R8
    hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_vld_i |=> $stable(status_q));

    // R9
    write_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_vld_i |=> (status_q == $past(nxt_i)));

endmodule

// File: rtl/mstat_core.sv
`timescale 1ns/1ps
module mstat_core
    import mstat_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            mach_we_i,
    input  logic [XLEN-1:0] mach_wdata_i,
    input  logic            supv_we_i,
    input  logic [XLEN-1:0] supv_wdata_i,
    output logic [XLEN-1:0] status_o,
    output logic [XLEN-1:0] supv_view_o,
    output logic            xlat_flush_o
);

    localparam logic [XLEN-1:0] SD_BIT  = XLEN'(1) << (XLEN - 1);
    localparam logic [XLEN-1:0] SV_MASK = XLEN'(SUPV_LOW) | SD_BIT;

    logic            wr_vld;
    logic [XLEN-1:0] wr_raw;
    logic [XLEN-1:0] wr_nxt;
    logic [XLEN-1:0] cur;

    mstat_arb #(.XLEN(XLEN)) u_arb (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .mach_we_i    (mach_we_i),
        .mach_wdata_i (mach_wdata_i),
        .supv_we_i    (supv_we_i),
        .supv_wdata_i (supv_wdata_i),
        .cur_i        (cur),
        .wr_vld_o     (wr_vld),
        .wr_raw_o     (wr_raw)
    );

    mstat_filter #(.XLEN(XLEN)) u_filter (
        .cur_i (cur),
        .raw_i (wr_raw),
        .nxt_o (wr_nxt)
    );

    mstat_reg #(.XLEN(XLEN)) u_reg (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_vld_i (wr_vld),
        .nxt_i    (wr_nxt),
        .status_o (cur),
        .flush_o  (xlat_flush_o)
    );

    assign status_o    = cur;
    assign supv_view_o = cur & SV_MASK;

    // R4
    supv_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((supv_view_o & ~SV_MASK) == '0) && ((supv_view_o ^ status_o) & SV_MASK) == '0);

endmodule

// File: tb/mstat_core_tb.sv
`timescale 1ns/1ps
module mstat_core_tb_top;

    localparam int XLEN = 64;
    localparam logic [63:0] MW  = 64'h0000_0000_007E_79AA;
    localparam logic [63:0] SV  = 64'h8000_0000_000D_E133;
    localparam logic [63:0] FL  = 64'h0000_0000_000E_1800;
    localparam logic [63:0] RST = 64'h0000_0000_0000_1800;

    typedef struct {
        logic [63:0] st;
        logic        fl;
        string       req;
    } item_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            mach_we = 1'b0;
    logic [XLEN-1:0] mach_wd = '0;
    logic            supv_we = 1'b0;
    logic [XLEN-1:0] supv_wd = '0;
    logic [XLEN-1:0] status;
    logic [XLEN-1:0] sview;
    logic            flush;

    item_t       sb[$];
    logic [63:0] model = RST;
    int          checks = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    mstat_core #(.XLEN(XLEN)) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .mach_we_i    (mach_we),
        .mach_wdata_i (mach_wd),
        .supv_we_i    (supv_we),
        .supv_wdata_i (supv_wd),
        .status_o     (status),
        .supv_view_o  (sview),
        .xlat_flush_o (flush)
    );

    // Model of the machine write path from R2 and R3
    function automatic logic [63:0] filt(input logic [63:0] cur, input logic [63:0] raw);
        logic [63:0] v;
        v = (cur & ~MW) | (raw & MW);
        v[63] = (v[14:13] == 2'b11) || (v[16:15] == 2'b11);
        return v;
    endfunction

    // Driver: apply one cycle of stimulus and queue the expected result
    task automatic drive(input logic me, input logic [63:0] md,
                         input logic se, input logic [63:0] sd, input string req);
        logic [63:0] nxt;
        logic        fl;
        item_t       it;
        @(negedge clk);
        mach_we = me;
        mach_wd = md;
        supv_we = se;
        supv_wd = sd;
        if (me) begin
            nxt = filt(model, md);
        end else if (se) begin
            nxt = filt(model, (model & ~SV) | (sd & SV));
        end else begin
            nxt = model;
        end
        fl = (me || se) && (((nxt ^ model) & FL) != 64'h0);
        it.st  = nxt;
        it.fl  = fl;
        it.req = req;
        sb.push_back(it);
        model = nxt;
    endtask

    // Monitor: compare one result per cycle, one cycle after the write (R9)
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                checks++;
                if (status !== it.st || sview !== (it.st & SV) || flush !== it.fl) begin
                    bad++;
                    $display("FAIL %s R4 R9: status=%h view=%h flush=%b expected status=%h view=%h flush=%b",
                             it.req, status, sview, flush, it.st, it.st & SV, it.fl);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog all requirements: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] x;
        x = 64'h9E37_79B9_7F4A_7C15;
        repeat (3) @(negedge clk);
        // R1 reset state
        checks++;
        if (status !== RST || sview !== 64'h0 || flush !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset: status=%h view=%h flush=%b expected status=%h view=0 flush=0",
                     status, sview, flush, RST);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (status !== RST || flush !== 1'b0) begin
            bad++;
            $display("FAIL R1 after release: status=%h flush=%b expected status=%h flush=0",
                     status, flush, RST);
        end

        drive(1'b1, '1, 1'b0, '0, "R2 R3 machine all ones");
        drive(1'b0, '0, 1'b0, '0, "R8 idle hold");
        drive(1'b1, '0, 1'b0, '0, "R2 R6 machine zero");
        drive(1'b0, '0, 1'b1, '1, "R5 supervisor all ones");
        drive(1'b1, model | 64'h8, 1'b0, '0, "R6 change without flush field");
        drive(1'b1, model ^ 64'h1800, 1'b0, '0, "R6 previous-privilege change");
        drive(1'b0, '0, 1'b1, ~SV, "R5 machine-only bits untouched by supervisor");
        drive(1'b1, '1, 1'b1, '0, "R7 both ports machine wins");
        drive(1'b1, 64'h4000, 1'b0, '0, "R3 FS=2 no summary");
        drive(1'b1, 64'h6000, 1'b0, '0, "R3 FS=3 summary");
        drive(1'b0, '0, 1'b1, 64'h8000_0000_0001_8011, "R5 UIE UPIE XS SD ignored");
        drive(1'b0, '0, 1'b0, '0, "R8 idle after write");
        drive(1'b1, model | 64'h2_0000, 1'b0, '0, "R6 MPRV set flush");

        for (int i = 0; i < 80; i++) begin
            logic [63:0] d1;
            logic [63:0] d2;
            x = x ^ (x << 13);
            x = x ^ (x >> 7);
            x = x ^ (x << 17);
            d1 = x;
            x = x ^ (x << 13);
            x = x ^ (x >> 7);
            x = x ^ (x << 17);
            d2 = x;
            drive(d1[60], d2, d1[61], d1, "R2 R3 R5 R6 R7 R8 mixed");
        end

        drive(1'b0, '0, 1'b0, '0, "R8 final idle");
        while (sb.size() != 0) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule